// File: doc/BRIEF.md
# Calendar Port Status Tracker

This block follows the flow-control status arriving on a packet interface's status channel. Each status slot is a 2-bit code for one port, and a programmable calendar decides which port each slot belongs to. The block keeps the calendar and walks it one entry per slot strobe. For every port it holds the last reported level and shows the matching grant. It also counts the cycles in which one chosen port is held off.

The calendar is 32 words of 17 bits. Each word packs four 4-bit port numbers and one odd-parity bit. Software loads the words, the calendar length and the enables through a simple register port while the interface is disabled. Once the interface and status enables are set and the length is non-zero, slots are consumed. A parity fault stops the walk and cancels every grant. The interface then trains until software drops the interface enable.

The state machine has four states:
- IDLE: interface disabled.
- WAIT: interface enabled but status not usable.
- RUN: walking the calendar.
- FAULT: a parity error was found.

The transitions are:
- IDLE→WAIT when the interface enable rises.
- WAIT→RUN when the status enable is set and the length is non-zero.
- RUN→WAIT when the status enable drops or the length becomes zero.
- RUN→FAULT on a slot whose calendar word fails parity.
- any state→IDLE when the interface enable drops.

Top module: `cal_status_tracker`

## Requirements
- R1: Calendar words are written with `reg_wr` and read with `reg_rd`. Read data appears on `reg_rdata` one clock after the read. Both accesses are ignored while `if_en` is 1, so the stored word and `reg_rdata` stay unchanged.
- R2: In word k, bits [3:0] are entry 4k, [7:4] are 4k+1, [11:8] are 4k+2 and [15:12] are 4k+3. In RUN, successive slots use entries 0 to `cfg_len`-1 and then wrap back to entry 0.
- R3: Slot code 00 (starving) or 01 (hungry) stores that level and sets the port's grant. Code 10 (satisfied) stores that level and clears the grant. Code 11 leaves the port's level unchanged but still consumes the calendar entry. Levels appear on `port_lvl[2p+1:2p]` one clock after the slot.
- R4: Bit 16 of a word is odd parity: the XOR of all 17 bits must be 1. If a slot reads a word that fails this check, then from the next clock `par_err` and `train` are 1 and all grants are 0. Later slots are then ignored until `if_en` drops.
- R5: After `if_en` rises with `st_en` set and `cfg_len` non-zero, `train` is 1 for one clock and 0 from the second clock on. While `cfg_len` is 0 or `st_en` is 0, `train` stays 1 and slots change nothing.
- R6: A port whose `ign_mask` bit is 1 shows level 00 and grant 1, whatever it reports.
- R7: `bp_cnt` increases by one on each clock in RUN in which the port selected by `bp_sel` has grant 0.
- R8: A counter write (`bp_wr`) with data all ones clears `bp_cnt`; the clear wins over a same-cycle increment. A write with any other data is ignored.
- R9: While `if_en` is 0, every port level is 10, every grant is 0, `par_err` is 0 and the calendar walk restarts at entry 0.
- R10: After reset, all levels are 10 and all grants 0. `train`, `par_err`, `bp_cnt` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| if_en | input | 1 | interface enable |
| st_en | input | 1 | status channel enable |
| cfg_len | input | 7 | number of calendar entries in use |
| ign_mask | input | 16 | per-port override of reported status |
| bp_sel | input | 4 | port watched by the backpressure counter |
| reg_wr | input | 1 | calendar word write strobe |
| reg_rd | input | 1 | calendar word read strobe |
| reg_addr | input | 5 | calendar word index |
| reg_wdata | input | 17 | calendar word to write |
| reg_rdata | output | 17 | calendar word read back |
| bp_wr | input | 1 | backpressure counter write strobe |
| bp_wdata | input | 32 | backpressure counter write data |
| slot_vld | input | 1 | status slot strobe |
| slot_stat | input | 2 | status code of the slot |
| port_lvl | output | 32 | two-bit flow-control level per port |
| port_grant | output | 16 | per-port grant |
| train | output | 1 | interface must send training |
| par_err | output | 1 | calendar parity fault seen |
| bp_cnt | output | 32 | backpressure cycle count |

## Verification
The counter clear and the counter increment can fall in the same cycle. The bench provokes this by writing all ones while the watched port is already satisfied in RUN, so an increment is pending on that same edge, and judges that `bp_cnt` reads zero afterwards rather than one. A parity fault and the grant update of the same slot also coincide. This is provoked with a corrupted second word, and the bench requires that the faulting slot leaves every grant at zero instead of updating its port.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        ST_STARVING  = 2'b00,
        ST_HUNGRY    = 2'b01,
        ST_SATISFIED = 2'b10,
        ST_FRAMING   = 2'b11
    } slot_stat_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_RUN   = 2'd2,
        S_FAULT = 2'd3
    } trk_state_e;
endpackage

// File: rtl/cst_cal_mem.sv
module cst_cal_mem #(
    parameter int NUM_WORDS = 32,
    parameter int LANES     = 4,
    parameter int PORT_W    = 4,
    localparam int WORD_W   = LANES * PORT_W + 1,
    localparam int ADDR_W   = $clog2(NUM_WORDS),
    localparam int LANE_W   = $clog2(LANES),
    localparam int IDX_W    = ADDR_W + LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [IDX_W-1:0]  look_idx,
    output logic [PORT_W-1:0] look_port,
    output logic              look_bad
);
    logic [WORD_W-1:0] mem [NUM_WORDS];
    logic [WORD_W-1:0] look_word;
    logic [PORT_W-1:0] lane [LANES];

    always_ff @(posedge clk) begin
        if (wr_en && !lock) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en && !lock) begin
            rdata <= mem[addr];
        end
    end

    assign look_word = mem[look_idx[IDX_W-1:LANE_W]];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = look_word[g*PORT_W +: PORT_W];
    end

    assign look_port = lane[look_idx[LANE_W-1:0]];
    // odd parity over the whole word: XOR must be 1
    assign look_bad  = ~(^look_word);

    AST_LOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock) |=> (mem[$past(addr)] == $past(mem[addr]))); // R1
    AST_LOCKED_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lock && !(wr_en && !lock)) |=> $stable(rdata)); // R1
endmodule

// File: rtl/cst_port_state.sv
module cst_port_state
    import cst_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_all,
    input  logic                   upd,
    input  logic [PORT_W-1:0]      upd_port,
    input  logic [1:0]             upd_stat,
    input  logic [NUM_PORTS-1:0]   ign_mask,
    output logic [2*NUM_PORTS-1:0] lvl,
    output logic [NUM_PORTS-1:0]   grant
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [1:0] st_q;
        logic [1:0] eff;
        logic       hit;

        assign hit = upd && (upd_port == PORT_W'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= ST_SATISFIED;
            end else if (clr_all) begin
                st_q <= ST_SATISFIED;
            end else if (hit && (upd_stat != ST_FRAMING)) begin
                st_q <= upd_stat;
            end
        end

        assign eff            = ign_mask[p] ? ST_STARVING : st_q;
        assign lvl[2*p +: 2]  = eff;
        assign grant[p]       = (eff != ST_SATISFIED);

        AST_CLEAR_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_all |=> (st_q == ST_SATISFIED)); // R9
        AST_FRAMING_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !clr_all && (upd_stat == ST_FRAMING)) |=> $stable(st_q)); // R3
    end
endmodule

// File: rtl/cst_bp_counter.sv
module cst_bp_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt
);
    logic clr;

    assign clr = wr_en && (&wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc) |=> (cnt == $past(cnt) + 1'b1)); // R7
endmodule

// File: rtl/cal_status_tracker.sv
module cal_status_tracker
    import cst_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter int NUM_WORDS = 32,
    parameter int LANES     = 4,
    parameter int CNT_W     = 32,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int ADDR_W   = $clog2(NUM_WORDS),
    localparam int IDX_W    = $clog2(NUM_WORDS * LANES),
    localparam int WORD_W   = LANES * PORT_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   if_en,
    input  logic                   st_en,
    input  logic [IDX_W-1:0]       cfg_len,
    input  logic [NUM_PORTS-1:0]   ign_mask,
    input  logic [PORT_W-1:0]      bp_sel,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [WORD_W-1:0]      reg_wdata,
    output logic [WORD_W-1:0]      reg_rdata,
    input  logic                   bp_wr,
    input  logic [CNT_W-1:0]       bp_wdata,
    input  logic                   slot_vld,
    input  logic [1:0]             slot_stat,
    output logic [2*NUM_PORTS-1:0] port_lvl,
    output logic [NUM_PORTS-1:0]   port_grant,
    output logic                   train,
    output logic                   par_err,
    output logic [CNT_W-1:0]       bp_cnt
);
    trk_state_e        state_q, state_d;
    logic [IDX_W-1:0]  ptr_q;
    logic [IDX_W:0]    ptr_inc;
    logic [IDX_W-1:0]  ptr_nxt;
    logic              run_ok, take, bad, good;
    logic [PORT_W-1:0] look_port;
    logic              look_bad;
    logic              par_err_q;
    logic              clr_all;
    logic              bp_inc;

    assign run_ok = if_en && st_en && (cfg_len != '0);
    assign take   = (state_q == S_RUN) && run_ok && slot_vld;
    assign bad    = take && look_bad;
    assign good   = take && !look_bad;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (if_en) state_d = S_WAIT;
            end
            S_WAIT: begin
                if (!if_en)      state_d = S_IDLE;
                else if (run_ok) state_d = S_RUN;
            end
            S_RUN: begin
                if (!if_en)       state_d = S_IDLE;
                else if (!run_ok) state_d = S_WAIT;
                else if (bad)     state_d = S_FAULT;
            end
            S_FAULT: begin
                if (!if_en) state_d = S_IDLE;
            end
        endcase
    end

    // outputs of the state machine
    always_comb begin
        train   = if_en && (state_q != S_RUN);
        par_err = par_err_q;
    end

    assign ptr_inc = {1'b0, ptr_q} + 1'b1;
    assign ptr_nxt = (ptr_inc >= {1'b0, cfg_len}) ? '0 : ptr_inc[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (state_q != S_RUN) begin
            ptr_q <= '0;
        end else if (good) begin
            ptr_q <= ptr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_err_q <= 1'b0;
        end else if (!if_en) begin
            par_err_q <= 1'b0;
        end else if (bad) begin
            par_err_q <= 1'b1;
        end
    end

    assign clr_all = !if_en || bad;
    assign bp_inc  = (state_q == S_RUN) && !port_grant[bp_sel];

    cst_cal_mem #(
        .NUM_WORDS (NUM_WORDS),
        .LANES     (LANES),
        .PORT_W    (PORT_W)
    ) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock      (if_en),
        .wr_en     (reg_wr),
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .look_idx  (ptr_q),
        .look_port (look_port),
        .look_bad  (look_bad)
    );

    cst_port_state #(
        .NUM_PORTS (NUM_PORTS)
    ) u_ports (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .upd      (good),
        .upd_port (look_port),
        .upd_stat (slot_stat),
        .ign_mask (ign_mask),
        .lvl      (port_lvl),
        .grant    (port_grant)
    );

    cst_bp_counter #(
        .CNT_W (CNT_W)
    ) u_bp (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bp_inc),
        .wr_en (bp_wr),
        .wdata (bp_wdata),
        .cnt   (bp_cnt)
    );

    AST_FAULT_TRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && if_en) |-> train); // R4
    AST_BAD_PARITY_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> ((state_q == S_FAULT) && par_err)); // R4
    AST_LEN_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_len == '0) |=> (state_q != S_RUN)); // R5
    AST_DISABLED_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |=> (!par_err && (state_q != S_RUN))); // R9
endmodule

// File: tb/cal_status_tracker_bench.sv
module cal_status_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        if_en, st_en;
    logic [6:0]  cfg_len;
    logic [15:0] ign_mask;
    logic [3:0]  bp_sel;
    logic        reg_wr, reg_rd;
    logic [4:0]  reg_addr;
    logic [16:0] reg_wdata, reg_rdata;
    logic        bp_wr;
    logic [31:0] bp_wdata;
    logic        slot_vld;
    logic [1:0]  slot_stat;
    logic [31:0] port_lvl;
    logic [15:0] port_grant;
    logic        train, par_err;
    logic [31:0] bp_cnt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cal_status_tracker u_cal_status_tracker (
        .clk(clk), .rst_n(rst_n), .if_en(if_en), .st_en(st_en),
        .cfg_len(cfg_len), .ign_mask(ign_mask), .bp_sel(bp_sel),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bp_wr(bp_wr), .bp_wdata(bp_wdata),
        .slot_vld(slot_vld), .slot_stat(slot_stat),
        .port_lvl(port_lvl), .port_grant(port_grant),
        .train(train), .par_err(par_err), .bp_cnt(bp_cnt)
    );

    // {stat[6:5], port[4:1], expected grant[0]}; calendar is 3,7,3,12,0,15
    localparam logic [6:0] VEC [8] = '{
        {2'b00, 4'd3,  1'b1},
        {2'b01, 4'd7,  1'b1},
        {2'b10, 4'd3,  1'b0},
        {2'b11, 4'd12, 1'b0},
        {2'b01, 4'd0,  1'b1},
        {2'b10, 4'd15, 1'b0},
        {2'b00, 4'd3,  1'b1},
        {2'b10, 4'd7,  1'b0}
    };

    function automatic logic [16:0] mkword(input logic [15:0] d);
        return {~(^d), d};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [4:0] a, input logic [16:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_word(input logic [4:0] a);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic slot(input logic [1:0] s);
        slot_vld = 1'b1; slot_stat = s;
        @(negedge clk);
        slot_vld = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; if_en = 0; st_en = 0; cfg_len = 0; ign_mask = 0; bp_sel = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; bp_wr = 0; bp_wdata = 0;
        slot_vld = 0; slot_stat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 grant", 32'(port_grant), 32'h0);
        check("R10 lvl", port_lvl, 32'hAAAA_AAAA);
        check("R10 train/par", {30'd0, train, par_err}, 32'h0);
        check("R10 cnt", bp_cnt, 32'h0);
        check("R10 rdata", 32'(reg_rdata), 32'h0);

        // load calendar: word0 = 3,7,3,12 ; word1 = 0,15
        wr_word(5'd0, mkword(16'hC373));
        wr_word(5'd1, mkword(16'h00F0));
        rd_word(5'd0);
        check("R1 R2 readback", 32'(reg_rdata), 32'(mkword(16'hC373)));

        cfg_len = 7'd6; bp_sel = 4'd7;
        if_en = 1'b1; st_en = 1'b1;
        @(negedge clk);
        check("R5 train first clock", 32'(train), 32'h1);
        @(negedge clk);
        check("R5 train released", 32'(train), 32'h0);

        // R2 R3 table walk
        for (int i = 0; i < 8; i++) begin
            slot(VEC[i][6:5]);
            check($sformatf("R3 R2 vec%0d", i), 32'(port_grant[VEC[i][4:1]]), 32'(VEC[i][0]));
        end
        check("R3 framing left port12 satisfied", 32'(port_lvl[25:24]), 32'h2);
        check("R3 hungry level port0", 32'(port_lvl[1:0]), 32'h1);

        // R8 clear collides with pending increment (port7 satisfied in RUN)
        bp_wr = 1'b1; bp_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bp_wr = 1'b0;
        check("R8 clear wins", bp_cnt, 32'h0);
        repeat (10) @(negedge clk);
        check("R7 count cycles", bp_cnt, 32'd10);
        bp_wr = 1'b1; bp_wdata = 32'hFFFF_FFFE;
        @(negedge clk);
        bp_wr = 1'b0;
        check("R8 non-ones write ignored", bp_cnt, 32'd11);

        // R6 ignore override
        ign_mask = 16'h0080;
        @(negedge clk);
        check("R6 ignored grant", 32'(port_grant[7]), 32'h1);
        check("R6 ignored level", 32'(port_lvl[15:14]), 32'h0);
        repeat (4) @(negedge clk);
        check("R7 R6 no count while granted", bp_cnt, 32'd11);
        ign_mask = 16'h0;

        // R1 locked access
        wr_word(5'd0, 17'h0);
        rd_word(5'd1);
        check("R1 locked read ignored", 32'(reg_rdata), 32'(mkword(16'hC373)));

        // R9 disable
        if_en = 1'b0;
        @(negedge clk);
        check("R9 grants cancelled", 32'(port_grant), 32'h0);
        check("R9 levels satisfied", port_lvl, 32'hAAAA_AAAA);
        rd_word(5'd0);
        check("R1 locked write ignored", 32'(reg_rdata), 32'(mkword(16'hC373)));

        // R4 parity fault on word1
        wr_word(5'd1, {~mkword(16'h00F0)[16], 16'h00F0});
        rd_word(5'd1);
        check("R1 raw word stored", 32'(reg_rdata), 32'({~mkword(16'h00F0)[16], 16'h00F0}));
        if_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) slot(2'b00);
        check("R2 walk restarted at 0", 32'(port_grant), 32'h1088);
        slot(2'b01);
        check("R4 par_err", 32'(par_err), 32'h1);
        check("R4 train", 32'(train), 32'h1);
        check("R4 grants cancelled", 32'(port_grant), 32'h0);
        slot(2'b00);
        check("R4 slots ignored", 32'(port_grant), 32'h0);
        if_en = 1'b0;
        @(negedge clk);
        check("R9 par_err cleared", {30'd0, par_err, train}, 32'h0);

        // R5 zero length and status disabled
        wr_word(5'd1, mkword(16'h00F0));
        cfg_len = 7'd0; if_en = 1'b1;
        repeat (3) @(negedge clk);
        slot(2'b00);
        check("R5 len0 train", 32'(train), 32'h1);
        check("R5 len0 slot ignored", 32'(port_grant), 32'h0);
        cfg_len = 7'd6; st_en = 1'b0;
        repeat (3) @(negedge clk);
        slot(2'b00);
        check("R5 st_en low train", 32'(train), 32'h1);
        check("R5 st_en low slot ignored", 32'(port_grant), 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule